// File: doc/BRIEF.md
# Link Bring-Up Controller

This block sequences the start-up of a serial transmit link. After reset it sits in a low-power idle state. It leaves idle only when the parallel input clock is present and the transmit PLL reports lock. If back-channel remote sensing is enabled, the controller then waits for a far-end receiver to be reported. Once a receiver is seen, it drives a training pattern of fixed length and then enters normal data transfer. If remote sensing is disabled, it goes from idle straight to normal transfer.

While the link is up, a break reported by the receiver sends the controller back to detection, provided remote sensing is on. Loss of the input clock or of PLL lock sends it all the way back to idle. For each new link with line encoding enabled, the controller forces the data-valid path high for a fixed number of parallel clocks, so that synchronisation characters go out before any payload. It also issues a one-cycle event pulse whenever the link comes up or goes down, for use by counters elsewhere.

Top module: `lbu_link_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `state_o` is 0 and `train_sel_o`, `datapath_en_o`, `sync_force_o` and `link_event_o` are all 0.
- R2: The controller stays in idle while `clk_present` and `pll_locked` are not both high. From any state, either of them being low at a clock edge puts the controller in idle after that edge.
- R3: When leaving idle, the controller goes to link-detect if `rsense_en` is high and directly to normal if it is low.
- R4: In link-detect the controller holds its state until `rx_detected` is high at a clock edge, and then moves to acquisition.
- R5: Acquisition lasts exactly `TRAIN_LEN` cycles with `train_sel_o` high throughout, and is followed by normal.
- R6: With `rsense_en` high, `link_broken` high in acquisition or normal moves the controller to link-detect at the next edge. With `rsense_en` low, `link_broken` has no effect in normal.
- R7: `datapath_en_o` is high exactly while the state is normal.
- R8: With `encode_en` high, `sync_force_o` is high for the first `SYNC_HOLD` cycles of every stay in normal and low after that. With `encode_en` low it is never high.
- R9: `link_event_o` is a one-cycle pulse in the first cycle of each stay in normal and in the first cycle after each stay in normal ends. It is low at all other times.
- R10: `state_o` encodes idle as 0, link-detect as 1, acquisition as 2 and normal as 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_present | input | 1 | Input clock is toggling |
| pll_locked | input | 1 | Transmit PLL is locked to the input clock |
| rsense_en | input | 1 | Remote-sense handshake enabled |
| encode_en | input | 1 | Line encoding enabled (static strap) |
| rx_detected | input | 1 | Far-end receiver seen on the line |
| link_broken | input | 1 | Receiver reports that it lost or failed lock |
| state_o | output | 2 | Current state: 0 idle, 1 detect, 2 acquisition, 3 normal |
| train_sel_o | output | 1 | Select the training pattern for transmission |
| datapath_en_o | output | 1 | Allow payload to reach the serialiser |
| sync_force_o | output | 1 | Force data-valid high so that sync characters are sent |
| link_event_o | output | 1 | One-cycle pulse on link up and on link down |

## Verification
A wrong state shows up on `state_o` in the same cycle, because every output is decoded from the state register with no further delay. A wrong dwell count shows up differently. An acquisition counter that is off by one changes the length of the `train_sel_o` run and moves the first `link_event_o` pulse by a cycle. A wrong sync window shows as a `sync_force_o` run that is not exactly `SYNC_HOLD` cycles long, and this is only seen when the window closes, up to `SYNC_HOLD` cycles after entry. A wrong priority between clock loss and link break shows one cycle after a stimulus that asserts both together, as detect where idle is expected.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

  typedef enum logic [1:0] {
    LBU_IDLE   = 2'd0,
    LBU_DETECT = 2'd1,
    LBU_ACQ    = 2'd2,
    LBU_NORMAL = 2'd3
  } lbu_state_e;

  // Link is considered up only in normal transfer
  function automatic logic lbu_is_link(lbu_state_e s);
    return s == LBU_NORMAL;
  endfunction

  // True when a move from a to b crosses the link-up boundary
  function automatic logic lbu_link_edge(lbu_state_e a, lbu_state_e b);
    return lbu_is_link(a) != lbu_is_link(b);
  endfunction

  // Transition rule. Clock or lock loss wins over everything else,
  // then a receiver break, then forward progress.
  function automatic lbu_state_e lbu_next(
    lbu_state_e cur,
    logic       clk_ok,
    logic       rs_en,
    logic       rx_seen,
    logic       broken,
    logic       train_done
  );
    lbu_state_e n;
    n = cur;
    if (!clk_ok) begin
      n = LBU_IDLE;
    end else begin
      unique case (cur)
        LBU_IDLE:   n = rs_en ? LBU_DETECT : LBU_NORMAL;
        LBU_DETECT: n = rx_seen ? LBU_ACQ : LBU_DETECT;
        LBU_ACQ: begin
          if (rs_en && broken)  n = LBU_DETECT;
          else if (train_done)  n = LBU_NORMAL;
          else                  n = LBU_ACQ;
        end
        LBU_NORMAL: n = (rs_en && broken) ? LBU_DETECT : LBU_NORMAL;
        default:    n = LBU_IDLE;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/lbu_dwell.sv
// Counts consecutive cycles with run high, saturating at LIMIT.
// in_window: run and fewer than LIMIT cycles elapsed.
// last: run and this is cycle LIMIT of the stay.
module lbu_dwell #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic in_window,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM   = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_M = CW'(LIMIT - 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            count_q <= '0;
    else if (!run)         count_q <= '0;
    else if (count_q < LIM) count_q <= count_q + 1'b1;
  end

  assign in_window = run && (count_q < LIM);
  assign last      = run && (count_q == LIM_M);

  // R5 R8
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= LIM);

  // R5 R8
  restart_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count_q == '0);
endmodule

// File: rtl/lbu_state_reg.sv
module lbu_state_reg
  import lbu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_ok,
  input  logic       rs_en,
  input  logic       rx_seen,
  input  logic       broken,
  input  logic       train_done,
  output lbu_state_e state_q,
  output lbu_state_e state_d
);
  assign state_d = lbu_next(state_q, clk_ok, rs_en, rx_seen, broken, train_done);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LBU_IDLE;
    else        state_q <= state_d;
  end

  // R4
  detect_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LBU_DETECT && clk_ok && !rx_seen) |=> state_q == LBU_DETECT);

  // R6
  break_to_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ok && rs_en && broken && (state_q == LBU_ACQ || state_q == LBU_NORMAL))
      |=> state_q == LBU_DETECT);
endmodule

// File: rtl/lbu_event.sv
module lbu_event
  import lbu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lbu_state_e state_cur,
  input  lbu_state_e state_nxt,
  output logic       pulse_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= lbu_link_edge(state_cur, state_nxt);
  end

  // R9
  pulse_matches_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q == (lbu_is_link(state_cur) != lbu_is_link($past(state_cur))));
endmodule

// File: rtl/lbu_link_ctrl.sv
module lbu_link_ctrl
  import lbu_pkg::*;
#(
  parameter int TRAIN_LEN = 64,
  parameter int SYNC_HOLD = 110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_present,
  input  logic       pll_locked,
  input  logic       rsense_en,
  input  logic       encode_en,
  input  logic       rx_detected,
  input  logic       link_broken,
  output logic [1:0] state_o,
  output logic       train_sel_o,
  output logic       datapath_en_o,
  output logic       sync_force_o,
  output logic       link_event_o
);
  // Named internal events, shared by the logic and the assertions
  lbu_state_e state_q;
  lbu_state_e state_d;
  logic       clk_ok;
  logic       in_acq;
  logic       in_norm;
  logic       train_last;
  logic       train_win;
  logic       sync_win;
  logic       sync_last;

  assign clk_ok  = clk_present && pll_locked;
  assign in_acq  = (state_q == LBU_ACQ);
  assign in_norm = (state_q == LBU_NORMAL);

  lbu_state_reg u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_ok     (clk_ok),
    .rs_en      (rsense_en),
    .rx_seen    (rx_detected),
    .broken     (link_broken),
    .train_done (train_last),
    .state_q    (state_q),
    .state_d    (state_d)
  );

  lbu_dwell #(.LIMIT(TRAIN_LEN)) u_train (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (in_acq),
    .in_window (train_win),
    .last      (train_last)
  );

  lbu_dwell #(.LIMIT(SYNC_HOLD)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (in_norm),
    .in_window (sync_win),
    .last      (sync_last)
  );

  lbu_event u_event (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_cur (state_q),
    .state_nxt (state_d),
    .pulse_q   (link_event_o)
  );

  assign state_o       = state_q;
  assign train_sel_o   = in_acq;
  assign datapath_en_o = in_norm;
  assign sync_force_o  = encode_en && sync_win;

  // R2
  clk_loss_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_present && pll_locked) |=> state_o == 2'd0);

  // R5
  train_then_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LBU_NORMAL && $past(state_q) == LBU_ACQ) |-> $past(train_last));

  // R5
  train_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_sel_o |-> train_win);

  // R8
  sync_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_force_o |-> (datapath_en_o && encode_en));

  // R8
  sync_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_last |=> !sync_force_o);
endmodule

// File: tb/test_lbu_link_ctrl.sv
module test_lbu_link_ctrl;
  localparam int TL = 20;
  localparam int SH = 110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_present = 0, pll_locked = 0, rsense_en = 0, encode_en = 0;
  logic rx_detected = 0, link_broken = 0;
  logic [1:0] state_o;
  logic train_sel_o, datapath_en_o, sync_force_o, link_event_o;

  always #10 clk = ~clk;

  lbu_link_ctrl #(.TRAIN_LEN(TL), .SYNC_HOLD(SH)) i_lbu_link_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_present(clk_present), .pll_locked(pll_locked),
    .rsense_en(rsense_en), .encode_en(encode_en), .rx_detected(rx_detected),
    .link_broken(link_broken), .state_o(state_o), .train_sel_o(train_sel_o),
    .datapath_en_o(datapath_en_o), .sync_force_o(sync_force_o),
    .link_event_o(link_event_o)
  );

  int n_checks = 0, n_err = 0;
  int cnt_train = 0, cnt_sync = 0, cnt_event = 0;
  int cyc = 0;
  bit done = 0;

  // Behavioural reference: state number, cycles spent in current state, event flag
  int m_state = 0, m_dwell = 0;
  bit m_event = 0;

  always @(posedge clk) begin
    int nx;
    if (!rst_n) begin
      m_state = 0; m_dwell = 0; m_event = 0;
    end else begin
      nx = m_state;
      if (!(clk_present && pll_locked)) nx = 0;
      else if (m_state == 0) nx = rsense_en ? 1 : 3;
      else if (m_state == 1) nx = rx_detected ? 2 : 1;
      else if (rsense_en && link_broken) nx = 1;
      else if (m_state == 2 && m_dwell == TL - 1) nx = 3;
      m_event = (nx == 3) != (m_state == 3);
      m_dwell = (nx == m_state) ? m_dwell + 1 : 0;
      m_state = nx;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R10 state", int'(state_o), m_state);
      chk("R5 train_sel", int'(train_sel_o), int'(m_state == 2));
      chk("R7 datapath_en", int'(datapath_en_o), int'(m_state == 3));
      chk("R8 sync_force", int'(sync_force_o),
          int'(m_state == 3 && encode_en && m_dwell < SH));
      chk("R9 link_event", int'(link_event_o), int'(m_event));
      cnt_train += int'(train_sel_o);
      cnt_sync  += int'(sync_force_o);
      cnt_event += int'(link_event_o);
    end
  endtask

  task automatic clear_counts();
    cnt_train = 0; cnt_sync = 0; cnt_event = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog (all): actual=%0d expected<=%0d cycles", cyc, 50000);
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    // R1 reset state
    chk("R1 reset state", int'(state_o), 0);
    chk("R1 reset outputs", int'({train_sel_o, datapath_en_o, sync_force_o, link_event_o}), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 first cycle after reset", int'(state_o), 0);
    // R2: no clock
    step(5);
    chk("R2 idle without clock", int'(state_o), 0);
    clk_present = 1;
    step(4);
    chk("R2 idle without lock", int'(state_o), 0);
    // R3: remote sense on -> detect
    rsense_en = 1; encode_en = 1; pll_locked = 1;
    step(1);
    chk("R3 idle to detect", int'(state_o), 1);
    step(10);
    chk("R4 detect holds", int'(state_o), 1);
    // R4/R5: acquisition and training length
    rx_detected = 1; clear_counts();
    step(1);
    chk("R4 detect to acq", int'(state_o), 2);
    rx_detected = 0;
    step(TL + 4);
    chk("R5 train length", cnt_train, TL);
    chk("R5 normal after train", int'(state_o), 3);
    chk("R9 one up event", cnt_event, 1);
    step(120);
    chk("R8 sync window length", cnt_sync, SH);
    // R6: break in normal
    link_broken = 1;
    step(1);
    link_broken = 0;
    chk("R6 normal break to detect", int'(state_o), 1);
    chk("R9 down event", cnt_event, 2);
    // R6: break in acquisition
    rx_detected = 1; step(1); rx_detected = 0; step(5);
    link_broken = 1; step(1); link_broken = 0;
    chk("R6 acq break to detect", int'(state_o), 1);
    // R2: clock loss from normal
    rx_detected = 1; step(1); rx_detected = 0; step(TL + 2);
    chk("R5 normal again", int'(state_o), 3);
    clk_present = 0; step(1);
    chk("R2 clock loss to idle", int'(state_o), 0);
    // R2 priority: clock loss with break together
    clk_present = 1; step(2);
    rx_detected = 1; step(1); rx_detected = 0; step(3);
    pll_locked = 0; link_broken = 1; step(1); link_broken = 0;
    chk("R2 lock loss beats break", int'(state_o), 0);
    // R3: remote sense off -> straight to normal, no encoding
    rsense_en = 0; encode_en = 0; pll_locked = 1; clear_counts();
    step(1);
    chk("R3 idle to normal", int'(state_o), 3);
    link_broken = 1; step(3); link_broken = 0;
    chk("R6 break ignored", int'(state_o), 3);
    step(120);
    chk("R8 no sync when encoding off", cnt_sync, 0);
    chk("R9 single event", cnt_event, 1);
    // R8 with encoding on, new link
    pll_locked = 0; step(1);
    encode_en = 1; pll_locked = 1; clear_counts();
    step(130);
    chk("R8 sync window new link", cnt_sync, SH);
    chk("R9 events down-up", cnt_event, 1);
    done = 1;
    summary();
    $finish;
  end
endmodule